// File: doc/BRIEF.md
# Way-Partitioned Victim Selector with Locking

This block picks the way to replace within one set of a set-associative cache. For each request it is given the state of every way in the addressed set: valid, dirty, locked and use bits, plus the stored address tag. It also receives the requester's identity, which is either one of several cores or the shared hardware agents. It keeps one eviction mask per requester. A 1 bit in a mask forbids that requester from evicting the way, and a 0 bit allows it. The block returns the way to fill, or a failure flag when no way may be used. It also raises a flag when the chosen line is dirty, so that an outside write-back path can act.

Lock requests use the same selection to allocate a line and pin it, but they take an existing line when the address already hits. Unlock requests look for the address in the set and, on a hit, report the way so that the caller clears its lock bit and flushes it. The tag and data arrays, the memory side and the write-back path all live outside this block. The caller applies the returned decision to the tag state.

Requests enter through a valid/ready handshake and results leave through a valid/ready handshake. There is one result register. A result stays on the outputs, unchanged, until `res_ready` is high. While a result is held, `req_ready` stays low, so back-pressure on the result side stalls the request side directly. Mask writes and their reject flag use plain control pins.

Top module: `victim_selector`

## Requirements
- R1: After reset no result is pending (`res_valid` low, `req_ready` high, `mask_err` low), and every requester's mask is all zeros, so every way is permitted.
- R2: A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Its result appears with `res_valid` high after that edge. The result holds steady while `res_ready` is low. `req_ready` equals `!res_valid || res_ready`. Results come out in request order.
- R3: For a fill (`req_op` 2'b00, and 2'b11, which is treated as a fill), the candidates are the ways that are permitted and unlocked. The victim is the lowest-numbered candidate whose valid bit is clear. A fill never reports a hit.
- R4: If no candidate is invalid, the victim is the lowest-numbered valid candidate whose use bit is 0. If every candidate has its use bit set, the victim is the lowest-numbered candidate.
- R5: A locked way is never returned as a victim. When no way is both permitted and unlocked, `res_fail` is 1, and `res_way`, `res_dirty`, `res_hit` and `res_flush` are all 0.
- R6: Requester ids below NUM_CORES select that core's mask. The id NUM_CORES, and any higher id, selects the hardware-agent mask. Masks apply to victim choice only.
- R7: A mask write (`mask_we`) stores `mask_wdata` into the mask of `mask_sel`. A write of all ones leaves that mask unchanged and pulses `mask_err` high for one cycle after the write.
- R8: A lock request (`req_op` 2'b01) whose tag hits a valid way returns that way with `res_hit` 1, whatever the masks and lock bits say. On a miss it selects a way exactly as a fill does, and it fails when every permitted way is locked.
- R9: An unlock request (`req_op` 2'b10) that hits returns the hit way with `res_hit` 1 and `res_flush` 1. An unlock that misses returns `res_hit`, `res_flush`, `res_fail` and `res_way` all 0.
- R10: When a way is reported, `res_dirty` is the dirty bit of that way, sampled when the request was taken. In every other case `res_dirty` is 0.
- R11: The set index is `req_addr[LINE_SHIFT +: SET_BITS]`, with LINE_SHIFT 7 for a 128-byte line, and it is returned on `res_index`. The tag compared against the ways is `req_addr[ADDR_W-1 : LINE_SHIFT+SET_BITS]`, and way i's tag is `way_tag[i*TAG_W +: TAG_W]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | ID_W | Requester whose mask is written |
| mask_wdata | input | WAYS | New mask; 1 forbids eviction from that way |
| mask_err | output | 1 | Pulses when an all-ones mask write was rejected |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 00 fill, 01 lock, 10 unlock, 11 fill |
| req_id | input | ID_W | Requester identity |
| req_addr | input | ADDR_W | Physical address of the line |
| way_valid | input | WAYS | Valid bit per way of the addressed set |
| way_dirty | input | WAYS | Dirty bit per way |
| way_lock | input | WAYS | Lock bit per way |
| way_use | input | WAYS | Use bit per way; 0 marks least recently used |
| way_tag | input | WAYS*TAG_W | Stored tag per way, way 0 in the low bits |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_op | output | 2 | Operation of this result |
| res_way | output | WAY_W | Chosen or hit way |
| res_fail | output | 1 | No usable way |
| res_hit | output | 1 | Lock or unlock matched a way |
| res_dirty | output | 1 | Reported way was dirty |
| res_flush | output | 1 | Unlocked line must be flushed |
| res_index | output | SET_BITS | Set index of the request |

## Verification
A stored mask that has been corrupted or wrongly accepted stays hidden until that requester's next fill. It then appears as a wrong `res_way` or a spurious `res_fail` one cycle after that request is taken. A wrong priority tier, or a lock bit that is ignored, shows on the very next result, so the stimulus places invalid, least-recently-used and locked ways so that each tier gives a different answer. A result register that is overwritten while stalled appears as a changed or lost result once `res_ready` returns, and the in-order comparison catches that.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    OP_FILL   = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_ALT    = 2'b11
  } vsel_op_e;
endpackage

// File: rtl/vsel_mask_bank.sv
module vsel_mask_bank #(
  parameter int WAYS      = 8,
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 3,
  localparam int NREQ     = NUM_CORES + 1,
  localparam int SLOT_W   = $clog2(NREQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ID_W-1:0]      sel,
  input  logic [WAYS-1:0]      wdata,
  input  logic [ID_W-1:0]      rd_id,
  output logic [WAYS-1:0]      rd_allow,
  output logic                 err,
  output logic [NREQ*WAYS-1:0] mask_flat
);
  logic [NREQ-1:0][WAYS-1:0] mask_q;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic              full_block;

  // ids at or above NUM_CORES share the hardware-agent slot
  assign wr_slot    = (int'(sel)   >= NUM_CORES) ? SLOT_W'(NUM_CORES) : SLOT_W'(sel);
  assign rd_slot    = (int'(rd_id) >= NUM_CORES) ? SLOT_W'(NUM_CORES) : SLOT_W'(rd_id);
  assign full_block = &wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      err    <= 1'b0;
    end else begin
      err <= we && full_block;
      if (we && !full_block) mask_q[wr_slot] <= wdata;
    end
  end

  assign rd_allow  = ~mask_q[rd_slot];
  assign mask_flat = mask_q;
endmodule

// File: rtl/vsel_hit.sv
module vsel_hit #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 19,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      tag,
  output logic [WAY_W-1:0]      way,
  output logic                  any
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) way = WAY_W'(i);
    end
  end

  assign any = |match;
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
  parameter int WAYS   = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  allow,
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  lock,
  input  logic [WAYS-1:0]  use_bit,
  output logic [WAY_W-1:0] way,
  output logic             none
);
  logic [WAYS-1:0] cand, empty, stale;

  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    cand  = allow & ~lock;
    empty = cand & ~valid;
    stale = cand & valid & ~use_bit;
    none  = ~|cand;
    if (|empty)      way = lowest(empty);
    else if (|stale) way = lowest(stale);
    else             way = lowest(cand);
  end
endmodule

// File: rtl/victim_selector.sv
module victim_selector
  import vsel_pkg::*;
#(
  parameter int WAYS       = 8,
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 7,
  parameter int SET_BITS   = 6,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int ID_W      = $clog2(NUM_CORES + 1),
  localparam int TAG_W     = ADDR_W - LINE_SHIFT - SET_BITS,
  localparam int NREQ      = NUM_CORES + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mask_we,
  input  logic [ID_W-1:0]       mask_sel,
  input  logic [WAYS-1:0]       mask_wdata,
  output logic                  mask_err,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [ID_W-1:0]       req_id,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS-1:0]       way_dirty,
  input  logic [WAYS-1:0]       way_lock,
  input  logic [WAYS-1:0]       way_use,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [1:0]            res_op,
  output logic [WAY_W-1:0]      res_way,
  output logic                  res_fail,
  output logic                  res_hit,
  output logic                  res_dirty,
  output logic                  res_flush,
  output logic [SET_BITS-1:0]   res_index
);
  logic                 accept;
  logic [TAG_W-1:0]     req_tag;
  logic [WAYS-1:0]      cur_allow;
  logic [NREQ*WAYS-1:0] mask_flat;
  logic [WAY_W-1:0]     hit_way, pick_way;
  logic                 hit_any, pick_none;
  logic [WAY_W-1:0]     n_way;
  logic                 n_fail, n_hit, n_dirty, n_flush;
  vsel_op_e             op;

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;
  assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
  assign op        = vsel_op_e'(req_op);

  vsel_mask_bank #(.WAYS(WAYS), .NUM_CORES(NUM_CORES), .ID_W(ID_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .sel(mask_sel), .wdata(mask_wdata),
    .rd_id(req_id), .rd_allow(cur_allow), .err(mask_err), .mask_flat(mask_flat)
  );

  vsel_hit #(.WAYS(WAYS), .TAG_W(TAG_W)) hit_i (
    .valid(way_valid), .tags(way_tag), .tag(req_tag), .way(hit_way), .any(hit_any)
  );

  vsel_pick #(.WAYS(WAYS)) pick_i (
    .allow(cur_allow), .valid(way_valid), .lock(way_lock), .use_bit(way_use),
    .way(pick_way), .none(pick_none)
  );

  always_comb begin
    n_way   = '0;
    n_fail  = 1'b0;
    n_hit   = 1'b0;
    n_dirty = 1'b0;
    n_flush = 1'b0;
    if (op == OP_UNLOCK) begin
      if (hit_any) begin
        n_hit   = 1'b1;
        n_flush = 1'b1;
        n_way   = hit_way;
        n_dirty = way_dirty[hit_way];
      end
    end else if (op == OP_LOCK && hit_any) begin
      n_hit   = 1'b1;
      n_way   = hit_way;
      n_dirty = way_dirty[hit_way];
    end else if (pick_none) begin
      n_fail = 1'b1;
    end else begin
      n_way   = pick_way;
      n_dirty = way_dirty[pick_way];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_op    <= '0;
      res_way   <= '0;
      res_fail  <= 1'b0;
      res_hit   <= 1'b0;
      res_dirty <= 1'b0;
      res_flush <= 1'b0;
      res_index <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_op    <= req_op;
      res_way   <= n_way;
      res_fail  <= n_fail;
      res_hit   <= n_hit;
      res_dirty <= n_dirty;
      res_flush <= n_flush;
      res_index <= req_addr[LINE_SHIFT +: SET_BITS];
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vsel_chk.sv
module vsel_chk #(
  parameter int WAYS     = 8,
  parameter int SET_BITS = 6,
  parameter int WAY_W    = 3,
  parameter int NREQ     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [WAYS-1:0]      way_lock,
  input logic [WAYS-1:0]      way_dirty,
  input logic [WAYS-1:0]      cur_allow,
  input logic                 mask_we,
  input logic [WAYS-1:0]      mask_wdata,
  input logic [NREQ*WAYS-1:0] mask_flat,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [1:0]           res_op,
  input logic [WAY_W-1:0]     res_way,
  input logic                 res_fail,
  input logic                 res_hit,
  input logic                 res_dirty,
  input logic                 res_flush,
  input logic [SET_BITS-1:0]  res_index
);
  logic [WAYS-1:0] lock_q, dirty_q, allow_q;
  logic            victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= '0;
      dirty_q <= '0;
      allow_q <= '0;
    end else if (req_valid && req_ready) begin
      lock_q  <= way_lock;
      dirty_q <= way_dirty;
      allow_q <= cur_allow;
    end
  end

  assign victim = res_valid && !res_fail && !res_hit && (res_op != 2'b10);

  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  // R2
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid &&
      $stable({res_op, res_way, res_fail, res_hit, res_dirty, res_flush, res_index})));

  // R5
  no_locked_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim |-> !lock_q[res_way]);

  // R6
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim |-> allow_q[res_way]);

  // R7
  reject_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && (&mask_wdata)) |=> $stable(mask_flat));

  // R9
  unlock_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op == 2'b10 && !res_hit) |-> (!res_flush && !res_fail));

  // R10
  dirty_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim |-> (res_dirty == dirty_q[res_way]));

  // R5
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fail) |-> (!res_hit && !res_dirty && !res_flush));
endmodule

bind victim_selector vsel_chk #(
  .WAYS(WAYS), .SET_BITS(SET_BITS), .WAY_W(WAY_W), .NREQ(NREQ)
) chk_i (.*);

// File: tb/victim_selector_tb_top.sv
`timescale 1ns/1ps
module victim_selector_tb_top;
  localparam int TAG_W = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_we = 1'b0;
  logic [2:0]  mask_sel = '0;
  logic [7:0]  mask_wdata = '0;
  logic        mask_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_id = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  way_valid = '0, way_dirty = '0, way_lock = '0, way_use = '0;
  logic [8*TAG_W-1:0] way_tag;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [1:0]  res_op;
  logic [2:0]  res_way;
  logic        res_fail, res_hit, res_dirty, res_flush;
  logic [5:0]  res_index;

  typedef struct {
    logic [14:0] v;
    int          rq;
  } exp_t;

  exp_t       q[$];
  logic [7:0] mdl[5];
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  victim_selector dut_i (.*);

  task automatic chk(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [18:0] t, input logic [5:0] idx);
    return {t, idx, 7'h00};
  endfunction

  // expected result built from the requirements
  function automatic logic [14:0] model(input logic [1:0] op, input logic [2:0] id,
                                         input logic [31:0] a);
    logic [7:0] allow;
    logic [2:0] way;
    logic fail, hit, dirty, flush;
    int hw, v;
    allow = ~mdl[(id >= 3'd4) ? 4 : int'(id)];
    way = 0; fail = 0; hit = 0; dirty = 0; flush = 0;
    hw = -1;
    for (int i = 7; i >= 0; i--)
      if (way_valid[i] && way_tag[i*TAG_W +: TAG_W] == a[31:13]) hw = i;
    if (op == 2'b10) begin
      if (hw >= 0) begin hit = 1; flush = 1; way = hw[2:0]; dirty = way_dirty[hw]; end
    end else if (op == 2'b01 && hw >= 0) begin
      hit = 1; way = hw[2:0]; dirty = way_dirty[hw];
    end else begin
      v = -1;
      for (int i = 7; i >= 0; i--) if (allow[i] && !way_lock[i] && !way_valid[i]) v = i;
      if (v < 0) for (int i = 7; i >= 0; i--) if (allow[i] && !way_lock[i] && !way_use[i]) v = i;
      if (v < 0) for (int i = 7; i >= 0; i--) if (allow[i] && !way_lock[i]) v = i;
      if (v < 0) fail = 1;
      else begin way = v[2:0]; dirty = way_dirty[v]; end
    end
    return {op, way, fail, hit, dirty, flush, a[12:7]};
  endfunction

  task automatic send(input logic [1:0] op, input logic [2:0] id, input logic [31:0] a,
                      input int rq);
    exp_t e;
    req_op = op; req_id = id; req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e.v = model(op, id, a);
    e.rq = rq;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wmask(input logic [2:0] id, input logic [7:0] val, input int rq);
    mask_sel = id; mask_wdata = val; mask_we = 1'b1;
    @(negedge clk);
    mask_we = 1'b0;
    chk(mask_err == (val == 8'hff), rq, {31'd0, mask_err}, {31'd0, val == 8'hff});
    if (val != 8'hff) mdl[(id >= 3'd4) ? 4 : int'(id)] = val;
  endtask

  task automatic set_ways(input logic [7:0] v, input logic [7:0] d,
                          input logic [7:0] l, input logic [7:0] u);
    way_valid = v; way_dirty = d; way_lock = l; way_use = u;
  endtask

  // monitor: compare each consumed result with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, 2, {17'd0, res_op, res_way, res_fail, res_hit, res_dirty, res_flush, res_index}, 32'd0);
      end else begin
        exp_t e;
        logic [14:0] got;
        e = q.pop_front();
        got = {res_op, res_way, res_fail, res_hit, res_dirty, res_flush, res_index};
        chk(got == e.v, e.rq, {17'd0, got}, {17'd0, e.v});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) way_tag[i*TAG_W +: TAG_W] = TAG_W'(i + 16);
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!res_valid, 1, {31'd0, res_valid}, 32'd0);
    chk(req_ready, 1, {31'd0, req_ready}, 32'd1);
    chk(!mask_err, 1, {31'd0, mask_err}, 32'd0);

    // R3 all invalid -> lowest way; R1 default masks allow everything
    set_ways(8'h00, 8'h00, 8'h00, 8'h00);
    send(2'b00, 3'd0, mk(19'h7ffff, 6'h01), 3);
    // R3 lowest invalid way
    set_ways(8'h07, 8'h00, 8'h00, 8'hff);
    send(2'b00, 3'd2, mk(19'h7ffff, 6'h02), 3);
    // R4 lowest least-recently-used way
    set_ways(8'hff, 8'h00, 8'h00, 8'hf3);
    send(2'b00, 3'd1, mk(19'h7ffff, 6'h03), 4);
    // R4 all used -> lowest candidate; op 11 behaves as fill
    set_ways(8'hff, 8'h00, 8'h00, 8'hff);
    send(2'b11, 3'd3, mk(19'h7ffff, 6'h04), 4);
    // R5 locked ways skipped
    set_ways(8'hff, 8'h00, 8'h03, 8'hff);
    send(2'b00, 3'd0, mk(19'h7ffff, 6'h05), 5);
    // R5 everything locked -> fail
    set_ways(8'hff, 8'hff, 8'hff, 8'h00);
    send(2'b00, 3'd0, mk(19'h7ffff, 6'h06), 5);

    // R6 per-core mask
    wmask(3'd1, 8'h0f, 7);
    set_ways(8'hff, 8'h00, 8'h00, 8'hff);
    send(2'b00, 3'd1, mk(19'h7ffff, 6'h07), 6);
    send(2'b00, 3'd0, mk(19'h7ffff, 6'h08), 6);
    // R6 hardware-agent mask, reached by id 4 and id 7
    wmask(3'd4, 8'hfe, 7);
    set_ways(8'h01, 8'h00, 8'h00, 8'hff);
    send(2'b00, 3'd4, mk(19'h7ffff, 6'h09), 6);
    send(2'b00, 3'd7, mk(19'h7ffff, 6'h0a), 6);
    send(2'b00, 3'd0, mk(19'h7ffff, 6'h0b), 6);

    // R7 all-ones write rejected, old mask for core 1 still in force
    wmask(3'd1, 8'hff, 7);
    set_ways(8'hff, 8'h00, 8'h00, 8'hff);
    send(2'b00, 3'd1, mk(19'h7ffff, 6'h0c), 7);

    // R8 lock hit ignores mask (core 1 forbids way 2)
    set_ways(8'hff, 8'h00, 8'h04, 8'hff);
    send(2'b01, 3'd1, mk(19'd18, 6'h0d), 8);
    // R8 lock miss with every permitted way locked -> fail
    set_ways(8'hff, 8'h00, 8'hf0, 8'h00);
    send(2'b01, 3'd1, mk(19'h7ffff, 6'h0e), 8);
    // R8 lock miss picks like a fill
    set_ways(8'hff, 8'h00, 8'h10, 8'h00);
    send(2'b01, 3'd1, mk(19'h7ffff, 6'h0f), 8);

    // R9 unlock hit -> flush
    set_ways(8'hff, 8'h20, 8'h20, 8'hff);
    send(2'b10, 3'd2, mk(19'd21, 6'h10), 9);
    // R9 unlock miss changes nothing (invalid way with matching tag too)
    set_ways(8'hdf, 8'h00, 8'h20, 8'hff);
    send(2'b10, 3'd2, mk(19'd21, 6'h11), 9);

    // R10 dirty victim reported; R11 index field carried through
    set_ways(8'hf7, 8'h08, 8'h00, 8'hff);
    send(2'b00, 3'd0, mk(19'h12345, 6'h2a), 10);
    // R11 tag compare uses the top address bits only
    set_ways(8'hff, 8'h00, 8'h00, 8'hff);
    send(2'b01, 3'd0, {19'd23, 6'h3f, 7'h7f}, 11);

    // R2 back-pressure
    @(posedge clk); #1 res_ready = 1'b0;
    @(negedge clk);
    set_ways(8'h00, 8'h00, 8'h00, 8'h00);
    send(2'b00, 3'd0, mk(19'h7ffff, 6'h15), 2);
    chk(!req_ready, 2, {31'd0, req_ready}, 32'd0);
    chk(res_valid, 2, {31'd0, res_valid}, 32'd1);
    fork
      send(2'b00, 3'd0, mk(19'h7ffff, 6'h16), 2);
    join_none
    repeat (3) @(negedge clk);
    chk(res_index == 6'h15, 2, {26'd0, res_index}, 32'h15);
    @(posedge clk); #1 res_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(q.size() == 0, 2, q.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule